// File: doc/BRIEF.md
# Shared Frame-Store Port Arbiter

This block sits in front of a single-port, 16-bit-wide SRAM that holds camera frames. Two clients share it. A frame writer takes an 8-bit greyscale pixel stream, pairs neighbouring pixels into 16-bit words and stores each frame in one of four fixed regions, which are used in rotation. A frame reader, working for a downstream segmentation path, asks for single words by naming a frame age and a word offset within that frame.

The writer is never refused. Its packed words pass through a small FIFO. The FIFO drains into the memory whenever the port is not held by a read. A read is accepted only when no write is waiting. It then holds the port for a fixed number of cycles and returns its word after a fixed latency. A pending read request simply waits, since no handshake beyond the grant is provided. If the FIFO would overflow, the incoming word is discarded and a sticky error flag is raised.

Top module: `fbuf_arbiter`

## Requirements
- R1: Each stored word holds the even-column pixel in bits 7:0 and the following odd-column pixel in bits 15:8. A word is queued only when its odd-column pixel arrives.
- R2: The memory word address is {region[1:0], offset[FRAME_W-1:0]}. The offset restarts at 0 with each start-of-frame pixel and increases by one for every queued word.
- R3: Reset places the region index at 3. Every pixel flagged as start-of-frame advances it by one, modulo 4. Frame n after reset is therefore written to region n mod 4, and the four latest frames stay readable.
- R4: A read of age A at offset O addresses region (current write region − A) mod 4 at offset O. Age 0 is the frame now being written.
- R5: rd_grant is high in a cycle only if rd_req is high, the write FIFO is empty and the port is not held by an earlier read. A request that is not granted has no effect.
- R6: A granted read drives sram_oe high, with a stable address and sram_we low, for RD_CYCLES cycles starting the cycle after the grant. sram_we and sram_oe are never high together.
- R7: rd_valid is high for exactly one cycle, RD_CYCLES+1 cycles after the grant cycle. In that cycle rd_data carries the addressed word.
- R8: If a word is pushed into a full FIFO in a cycle with no pop, that word is dropped and ovf_err rises. ovf_err then stays high until reset. Under the default parameters with an unbroken pixel stream, no overflow occurs.
- R9: A start-of-frame pixel is always treated as column 0. A lone even pixel left over at the end of the previous frame is never written.
- R10: During and right after reset, sram_we, sram_oe, rd_valid and ovf_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | Pixel is the first of a new frame |
| pix_data | input | 8 | Greyscale pixel |
| rd_req | input | 1 | Read request, held until granted |
| rd_age | input | 2 | Frame age relative to the frame being written |
| rd_off | input | FRAME_W | Word offset within the frame |
| rd_grant | output | 1 | Read request accepted this cycle |
| rd_valid | output | 1 | rd_data valid |
| rd_data | output | 16 | Returned word |
| sram_addr | output | FRAME_W+2 | Memory word address |
| sram_wdata | output | 16 | Memory write data |
| sram_rdata | input | 16 | Memory read data |
| sram_we | output | 1 | Memory write enable |
| sram_oe | output | 1 | Memory output enable |
| ovf_err | output | 1 | Sticky write-FIFO overflow flag |

## Verification
The assertions assume that rd_req is held steady, with a fixed age and offset, until it is granted. They also assume that the memory presents the addressed word on sram_rdata combinationally for as long as sram_oe is high. The bench's memory model behaves in exactly that way, and each read request is kept high until the cycle in which the bench sees the grant. The checks for overflow and latency depend on RD_CYCLES being at least 2. The bench therefore builds its overflow instance with a long read hold of 12 cycles, rather than forcing the FIFO by any other means.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

    localparam int PIX_W       = 8;
    localparam int WORD_W      = 2 * PIX_W;
    localparam int IDX_W       = 2;
    localparam int NUM_REGIONS = 1 << IDX_W;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  region_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } port_op_e;

    // Region that holds the frame of the given age (0 = being written).
    function automatic region_t age_to_region(input region_t wr_region,
                                              input region_t age);
        return wr_region - age;
    endfunction

endpackage

// File: rtl/fbuf_packer.sv
module fbuf_packer
    import fbuf_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_valid,
    input  logic               pix_sof,
    input  pix_t               pix_data,
    output logic               push,
    output word_t              push_word,
    output logic [FRAME_W-1:0] push_off,
    output region_t            region
);

    logic               have_low;
    pix_t               low_q;
    logic [FRAME_W-1:0] off_q;
    region_t            region_q;

    // An odd-column pixel completes a word; a start-of-frame pixel never does.
    assign push      = pix_valid && !pix_sof && have_low;
    assign push_word = {pix_data, low_q};
    assign push_off  = off_q;
    assign region    = region_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_low <= 1'b0;
            low_q    <= '0;
            off_q    <= '0;
            region_q <= region_t'(NUM_REGIONS - 1);
        end else if (pix_valid) begin
            if (pix_sof) begin
                region_q <= region_q + region_t'(1);
                off_q    <= '0;
                low_q    <= pix_data;
                have_low <= 1'b1;
            end else if (have_low) begin
                off_q    <= off_q + FRAME_W'(1);
                have_low <= 1'b0;
            end else begin
                low_q    <= pix_data;
                have_low <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fbuf_wfifo.sv
module fbuf_wfifo #(
    parameter int WIDTH = 26,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_wr, do_rd;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign do_rd = pop && !empty;
    assign do_wr = push && (!full || do_rd);
    assign head  = store[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            if (do_wr && !do_rd)      count <= count + CNT_W'(1);
            else if (do_rd && !do_wr) count <= count - CNT_W'(1);
            if (push && !do_wr) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/fbuf_port.sv
module fbuf_port
    import fbuf_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int RD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [ADDR_W-1:0] head_addr,
    input  word_t             head_data,
    output logic              pop,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_grant,
    output logic              rd_valid,
    output word_t             rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output word_t             sram_wdata,
    input  word_t             sram_rdata,
    output logic              sram_we,
    output logic              sram_oe
);

    localparam int CNT_W = $clog2(RD_CYCLES + 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             held;
    port_op_e         op;

    // Port still owned by a read during the next cycle.
    assign held     = hold_cnt > CNT_W'(1);
    assign pop      = !fifo_empty && !held;
    assign rd_grant = rd_req && fifo_empty && !held;

    always_comb begin
        if (pop)           op = OP_WRITE;
        else if (rd_grant) op = OP_READ;
        else               op = OP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt   <= '0;
            sram_we    <= 1'b0;
            sram_oe    <= 1'b0;
            sram_addr  <= '0;
            sram_wdata <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            sram_we  <= (op == OP_WRITE);
            sram_oe  <= (op == OP_READ) || held;
            rd_valid <= (hold_cnt == CNT_W'(1));
            if (hold_cnt == CNT_W'(1)) rd_data <= sram_rdata;
            case (op)
                OP_WRITE: begin
                    sram_addr  <= head_addr;
                    sram_wdata <= head_data;
                end
                OP_READ:  sram_addr <= rd_addr;
                default:  ;
            endcase
            if (op == OP_READ)          hold_cnt <= CNT_W'(RD_CYCLES);
            else if (hold_cnt != '0)    hold_cnt <= hold_cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/fbuf_arbiter.sv
module fbuf_arbiter
    import fbuf_pkg::*;
#(
    parameter int FRAME_W    = 8,
    parameter int RD_CYCLES  = 2,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pix_valid,
    input  logic                     pix_sof,
    input  logic [7:0]               pix_data,
    input  logic                     rd_req,
    input  logic [1:0]               rd_age,
    input  logic [FRAME_W-1:0]       rd_off,
    output logic                     rd_grant,
    output logic                     rd_valid,
    output logic [15:0]              rd_data,
    output logic [FRAME_W+1:0]       sram_addr,
    output logic [15:0]              sram_wdata,
    input  logic [15:0]              sram_rdata,
    output logic                     sram_we,
    output logic                     sram_oe,
    output logic                     ovf_err
);

    localparam int ADDR_W = IDX_W + FRAME_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        word_t             data;
    } wr_entry_t;

    logic               push, pop, fifo_empty;
    word_t              push_word;
    logic [FRAME_W-1:0] push_off;
    region_t            wr_region;
    wr_entry_t          in_entry, head_entry;
    logic [ADDR_W-1:0]  rd_addr;

    fbuf_packer #(.FRAME_W(FRAME_W)) u_packer (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_sof   (pix_sof),
        .pix_data  (pix_data),
        .push      (push),
        .push_word (push_word),
        .push_off  (push_off),
        .region    (wr_region)
    );

    assign in_entry = '{addr: {wr_region, push_off}, data: push_word};

    fbuf_wfifo #(.WIDTH($bits(wr_entry_t)), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (in_entry),
        .pop   (pop),
        .head  (head_entry),
        .empty (fifo_empty),
        .ovf   (ovf_err)
    );

    assign rd_addr = {age_to_region(wr_region, rd_age), rd_off};

    fbuf_port #(.ADDR_W(ADDR_W), .RD_CYCLES(RD_CYCLES)) u_port (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .head_addr  (head_entry.addr),
        .head_data  (head_entry.data),
        .pop        (pop),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_grant   (rd_grant),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata),
        .sram_we    (sram_we),
        .sram_oe    (sram_oe)
    );

endmodule

// File: rtl/fbuf_arbiter_chk.sv
module fbuf_arbiter_chk #(
    parameter int FRAME_W   = 8,
    parameter int RD_CYCLES = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_req,
    input logic               rd_grant,
    input logic               rd_valid,
    input logic [FRAME_W+1:0] sram_addr,
    input logic               sram_we,
    input logic               sram_oe,
    input logic               ovf_err
);

    logic [RD_CYCLES:0] grant_hist;

    always_ff @(posedge clk) begin
        if (rst) grant_hist <= '0;
        else     grant_hist <= {grant_hist[RD_CYCLES-1:0], rd_grant};
    end

    // R6: one port, never written and read together
    a_r6_we_oe_excl: assert property (@(posedge clk) disable iff (rst)
        !(sram_we && sram_oe));

    // R6: a granted read owns the port next cycle, no write there
    a_r6_read_owns_port: assert property (@(posedge clk) disable iff (rst)
        rd_grant |=> (sram_oe && !sram_we));

    // R6: address held while one read keeps the port
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (sram_oe && $past(sram_oe) && !$past(rd_grant)) |-> $stable(sram_addr));

    // R5: no grant without a request, none in the cycle after a grant
    a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
        rd_grant |-> rd_req);

    a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        rd_grant |=> !rd_grant);

    // R7: fixed return latency
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
        rd_valid == grant_hist[RD_CYCLES]);

    // R8: error flag is sticky
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

endmodule

bind fbuf_arbiter fbuf_arbiter_chk #(.FRAME_W(FRAME_W), .RD_CYCLES(RD_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_grant  (rd_grant),
    .rd_valid  (rd_valid),
    .sram_addr (sram_addr),
    .sram_we   (sram_we),
    .sram_oe   (sram_oe),
    .ovf_err   (ovf_err)
);

// File: tb/fbuf_arbiter_tb.sv
module fbuf_arbiter_tb;

    localparam int FRAME_W = 8;
    localparam int AW      = FRAME_W + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // main instance
    logic          pix_valid = 0, pix_sof = 0;
    logic [7:0]    pix_data = 0;
    logic          rd_req = 0;
    logic [1:0]    rd_age = 0;
    logic [7:0]    rd_off = 0;
    logic          rd_grant, rd_valid, sram_we, sram_oe, ovf_err;
    logic [15:0]   rd_data, sram_wdata, sram_rdata;
    logic [AW-1:0] sram_addr;

    fbuf_arbiter #(.FRAME_W(FRAME_W)) u_dut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_data(pix_data), .rd_req(rd_req), .rd_age(rd_age), .rd_off(rd_off),
        .rd_grant(rd_grant), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .sram_we(sram_we), .sram_oe(sram_oe), .ovf_err(ovf_err)
    );

    logic [15:0] mem [0:(1<<AW)-1];
    initial for (int i = 0; i < (1<<AW); i++) mem[i] = 16'h0000;
    always @(posedge clk) if (sram_we) mem[sram_addr] <= sram_wdata;
    assign sram_rdata = sram_oe ? mem[sram_addr] : 16'h0000;

    // long-hold instance for the overflow case
    logic          o_valid = 0, o_sof = 0, o_req = 0;
    logic [7:0]    o_pix = 0;
    logic          o_grant, o_rvalid, o_we, o_oe, o_ovf;
    logic [15:0]   o_rdata, o_wdata;
    logic [AW-1:0] o_addr;

    fbuf_arbiter #(.FRAME_W(FRAME_W), .RD_CYCLES(12)) u_ovf (
        .clk(clk), .rst(rst), .pix_valid(o_valid), .pix_sof(o_sof),
        .pix_data(o_pix), .rd_req(o_req), .rd_age(2'd0), .rd_off(8'd0),
        .rd_grant(o_grant), .rd_valid(o_rvalid), .rd_data(o_rdata),
        .sram_addr(o_addr), .sram_wdata(o_wdata), .sram_rdata(16'h0000),
        .sram_we(o_we), .sram_oe(o_oe), .ovf_err(o_ovf)
    );

    // {age, offset, expected address, expected word}
    localparam logic [35:0] VEC [0:8] = '{
        {2'd0, 8'd0, 10'h000, 16'h4140},
        {2'd0, 8'd3, 10'h003, 16'h4746},
        {2'd1, 8'd1, 10'h301, 16'h3332},
        {2'd1, 8'd0, 10'h300, 16'h3130},
        {2'd1, 8'd4, 10'h304, 16'h0000},
        {2'd2, 8'd2, 10'h202, 16'h2524},
        {2'd2, 8'd3, 10'h203, 16'h2726},
        {2'd3, 8'd3, 10'h103, 16'h1716},
        {2'd3, 8'd0, 10'h100, 16'h1110}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input int n, input int npix);
        for (int k = 0; k < npix; k++) begin
            @(negedge clk);
            pix_valid = 1;
            pix_sof   = (k == 0);
            pix_data  = 8'(n * 16 + k);
        end
        @(negedge clk);
        pix_valid = 0;
        pix_sof   = 0;
    endtask

    task automatic do_read(input logic [1:0] age, input logic [7:0] off,
                           input logic [AW-1:0] eaddr, input logic [15:0] edata);
        @(negedge clk);
        rd_req = 1; rd_age = age; rd_off = off;
        #1 check("R5 grant when idle", 32'(rd_grant), 32'd1);
        @(negedge clk);
        rd_req = 0;
        #1 check("R6 oe during read", 32'(sram_oe && !sram_we), 32'd1);
        check("R4 read address", 32'(sram_addr), 32'(eaddr));
        check("R7 no early valid", 32'(rd_valid), 32'd0);
        @(negedge clk);
        #1 check("R7 no early valid", 32'(rd_valid), 32'd0);
        @(negedge clk);
        #1 check("R7 valid at latency", 32'(rd_valid), 32'd1);
        check("R1 R3 read data", 32'(rd_data), 32'(edata));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check("R10 we in reset", 32'(sram_we), 32'd0);
        check("R10 oe in reset", 32'(sram_oe), 32'd0);
        @(negedge clk);
        rst = 0;
        #1 check("R10 rd_valid after reset", 32'(rd_valid), 32'd0);
        check("R10 ovf_err after reset", 32'(ovf_err), 32'd0);

        // frames 0..4; frame 3 ends on a lone even pixel (R9)
        send_frame(0, 8);
        send_frame(1, 8);
        send_frame(2, 8);
        send_frame(3, 9);
        send_frame(4, 8);
        repeat (4) @(negedge clk);

        // R2 R3 R4 R9 via table; region rotation seen in entry 0
        for (int v = 0; v < 9; v++) begin
            do_read(VEC[v][35:34], VEC[v][33:26], VEC[v][25:16], VEC[v][15:0]);
        end

        // R5: a queued write beats a waiting read
        @(negedge clk);
        pix_valid = 1; pix_sof = 0; pix_data = 8'hA0;
        @(negedge clk);
        pix_data = 8'hA1;
        @(negedge clk);
        pix_valid = 0; rd_req = 1; rd_age = 2'd0; rd_off = 8'd4;
        #1 check("R5 no grant with word queued", 32'(rd_grant), 32'd0);
        @(negedge clk);
        #1 check("R5 write issued first", 32'(sram_we), 32'd1);
        check("R2 write address", 32'(sram_addr), 32'h004);
        check("R5 grant after drain", 32'(rd_grant), 32'd1);
        @(negedge clk);
        rd_req = 0;
        @(negedge clk);
        @(negedge clk);
        #1 check("R7 valid after write-first", 32'(rd_valid), 32'd1);
        check("R1 pair order", 32'(rd_data), 32'h0000A1A0);
        check("R8 no overflow default", 32'(ovf_err), 32'd0);

        // R8: long read hold on u_ovf, then a dense pixel burst
        @(negedge clk);
        o_req = 1;
        #1 check("R5 ovf instance grant", 32'(o_grant), 32'd1);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            o_req = 0; o_valid = 1; o_sof = (k == 0); o_pix = 8'(k);
        end
        @(negedge clk);
        o_valid = 0; o_sof = 0;
        #1 check("R8 overflow flagged", 32'(o_ovf), 32'd1);
        repeat (20) @(negedge clk);
        #1 check("R8 flag sticky", 32'(o_ovf), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule